// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves pixel data and commands between a host register interface and a smart display panel attached over an 8- or 16-bit parallel bus. The host sets up a transfer in a few control registers: strobe timing, bus width and words per pick, the number of bus cycles, and the command/data select. It pushes 32-, 16- or 8-bit values into a write queue. Once the transfer is opened, the engine splits each queued value into bus-width slices and emits them as strobed bus cycles until the programmed cycle count runs out.

Reads use the same cycle timing with the read strobe. The value sampled in each read cycle lands in a small capture queue that the host drains through the same data register. All strobe phases are counted in ticks of a divided clock.

An identification register lets software check that the block is present. After it is cleared by a write, it returns two alternating sync patterns, then a component code, then a version word.

Top module: `pbus_xfer_engine`

Register word addresses: 0 identification, 1 timing/transfer, 2 mode/status, 3 pick, 4 data queue, 5 divider. The timing register has these fields:
- bits 17:0: cycles minus one
- bit 18: command/data select
- bits 23:20: active phase minus one
- bits 29:24: recovery phase minus one
- bit 30: chip-select level

The mode register has these fields:
- bit 0: enable
- bit 1: hold in reset
- bit 2: read direction
- bit 3: drained status, read only
- bit 4: write-strobe gate, where 1 closes the gate

The pick register holds the width minus one in bits 4:0 and the slice count minus one in bits 9:5. The divider register holds the divide value minus one.

## Requirements
- R1: After reset, pb_csn, pb_wen and pb_ren are 1. The mode register reads 0x18 (drained, gate closed). The timing register reads 0x42000000.
- R2: After a write to address 0, the next four reads of address 0 return 0x55555555, 0xAAAAAAAA, the component code (default 0x0000D15B) and the version (default 0x00020001). Further reads keep returning the version.
- R3: The active phase lasts TW0 ticks and the recovery phase lasts TW1 ticks, with both fields stored minus one. A tick is DIV clocks, with the divider field holding DIV minus one. Back-to-back cycles start every (TW0+TW1)*DIV clocks, and pb_dout is stable while the strobe is low.
- R4: Opening a transfer loads the cycle count. Exactly count+1 bus cycles are then issued, even when more data is queued.
- R5: pb_cd equals timing bit 18 for every cycle of the transfer.
- R6: Cycles run only while these four conditions all hold: enable is 1, hold-in-reset is 0, timing bit 30 is 0 and the gate is 0. pb_csn follows bit 30 and is low during every strobe.
- R7: With width 8 and four picks, a 32-bit value leaves as four byte cycles, least significant byte first. With width 16 and two picks, it leaves as two halfword cycles, low half first. The unused upper bus bits are 0.
- R8: Data-register writes of size 0 (byte) or 1 (halfword) queue a partial value. A byte gives one cycle. A halfword gives two cycles at width 8 and one cycle at width 16. Slices leave low-order first, and the bits above the written size are zero.
- R9: Mode bit 3 is 0 while any cycle is in progress or queued write data remains. It returns to 1 once all of it has completed.
- R10: If a cycle is about to start with a recovery field below 2 (TW1 < 3 ticks), no strobe is issued. The engine resets itself instead: it flushes both queues and clears the enable bit.
- R11: With the read direction set, each cycle pulses pb_ren instead of pb_wen. pb_din is sampled one tick after pb_ren rises and pushed into the capture queue, zero-extended to the bus width. Reads of address 4 pop it and return 0 when it is empty.
- R12: While hold-in-reset is 1, no strobe is driven, both queues are emptied and data-register writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid on reg_rdata the next cycle |
| reg_addr | input | 3 | Register word address |
| reg_wsize | input | 2 | Data register write size: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pb_din | input | 16 | Panel bus read data |
| pb_dout | output | 16 | Panel bus write data |
| pb_doe | output | 1 | Bus output enable during write transfers |
| pb_csn | output | 1 | Chip select, active low |
| pb_wen | output | 1 | Write strobe, active low |
| pb_ren | output | 1 | Read strobe, active low |
| pb_cd | output | 1 | Command (0) or data (1) select |

## Verification
The assertions take for granted that the host leaves the timing register, the bus width and the direction bit unchanged while a transfer is open. They also assume the host closes chip select only after the last strobe has finished. The stimulus keeps to this: each transfer is programmed with chip select high and the gate closed, then opened, run for longer than its computed length, and only then closed. Random cases draw the phase counts, divider, width, select line and mixed write sizes from a fixed seed. The recovery phase is kept at 3 ticks or more, except in the one directed case that exercises the self-reset.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int BUS_W = 16;
  localparam int CNT_W = 18;
  localparam int TW0_W = 4;
  localparam int TW1_W = 6;
  localparam int PICK_W = 10;

  localparam logic [2:0] ADR_ID     = 3'd0;
  localparam logic [2:0] ADR_TIMING = 3'd1;
  localparam logic [2:0] ADR_MODE   = 3'd2;
  localparam logic [2:0] ADR_PICK   = 3'd3;
  localparam logic [2:0] ADR_FIFO   = 3'd4;
  localparam logic [2:0] ADR_DIV    = 3'd5;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [31:0] SYNC_A     = 32'h5555_5555;
  localparam logic [31:0] SYNC_B     = 32'hAAAA_AAAA;
  localparam logic [31:0] TIMING_RST = 32'h4200_0000;
  localparam logic [PICK_W-1:0] PICK_RST = 10'h067;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ACT, SEQ_REST} seq_state_e;

  // Number of bus slices one queued entry produces.
  function automatic logic [2:0] slice_count(logic [1:0] size, logic w16, logic [4:0] pc_m1);
    logic [5:0] want;
    logic [2:0] cap;
    cap  = w16 ? 3'd2 : 3'd4;
    want = {1'b0, pc_m1} + 6'd1;
    if (size == SZ_BYTE) return 3'd1;
    if (size == SZ_HALF) return w16 ? 3'd1 : 3'd2;
    return (want > {3'b000, cap}) ? cap : want[2:0];
  endfunction

  function automatic logic [31:0] size_mask(logic [1:0] size, logic [31:0] d);
    if (size == SZ_BYTE) return {24'h0, d[7:0]};
    if (size == SZ_HALF) return {16'h0, d[15:0]};
    return d;
  endfunction
endpackage

// File: rtl/pbus_fifo.sv
module pbus_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 8
)(
  input  logic         clk,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/pbus_tick_div.sv
module pbus_tick_div #(
  parameter int DW = 3
)(
  input  logic          clk,
  input  logic          clr,
  input  logic [DW-1:0] div_m1,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = (cnt >= div_m1);

  always_ff @(posedge clk) begin
    if (clr || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pbus_strobe_seq.sv
module pbus_strobe_seq
  import pbus_pkg::*;
#(
  parameter int T0W = 4,
  parameter int T1W = 6
)(
  input  logic           clk,
  input  logic           clr,
  input  logic           tick,
  input  logic           req,
  input  logic [T0W-1:0] tw0_m1,
  input  logic [T1W-1:0] tw1_m1,
  output logic           strobe_on,
  output logic           accept,
  output logic           fault,
  output logic           sample,
  output logic           busy
);
  localparam int CW = (T0W > T1W) ? T0W : T1W;

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          slot, bad;

  // A new cycle may begin from idle or on the last recovery tick.
  assign slot      = tick && ((st == SEQ_IDLE) || (st == SEQ_REST && cnt == '0));
  assign bad       = (tw1_m1 < T1W'(2));
  assign accept    = slot && req && !bad;
  assign fault     = slot && req && bad;
  assign sample    = tick && (st == SEQ_REST) && (cnt == CW'(tw1_m1));
  assign strobe_on = (st == SEQ_ACT);
  assign busy      = (st != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (clr) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        SEQ_IDLE: if (accept) begin
          st  <= SEQ_ACT;
          cnt <= CW'(tw0_m1);
        end
        SEQ_ACT: if (cnt == '0) begin
          st  <= SEQ_REST;
          cnt <= CW'(tw1_m1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        SEQ_REST: if (cnt == '0) begin
          if (accept) begin
            st  <= SEQ_ACT;
            cnt <= CW'(tw0_m1);
          end else begin
            st <= SEQ_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbus_xfer_engine.sv
module pbus_xfer_engine
  import pbus_pkg::*;
#(
  parameter int          WFIFO_DEPTH = 8,
  parameter int          RFIFO_DEPTH = 8,
  parameter int          DIV_W       = 3,
  parameter logic [31:0] COMP_CODE   = 32'h0000_D15B,
  parameter logic [31:0] VERSION_ID  = 32'h0002_0001
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [1:0]       reg_wsize,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [BUS_W-1:0] pb_din,
  output logic [BUS_W-1:0] pb_dout,
  output logic             pb_doe,
  output logic             pb_csn,
  output logic             pb_wen,
  output logic             pb_ren,
  output logic             pb_cd
);
  localparam int WENT_W = 34;

  // Programmed state
  logic [31:0]       timing;
  logic              mode_en, mode_rst, mode_dir, mode_gate;
  logic [PICK_W-1:0] pick;
  logic [DIV_W-1:0]  divr;
  logic [1:0]        id_idx;

  // Engine state
  logic              go, go_q, start, done;
  logic [CNT_W-1:0]  rem;
  logic              eng_clr, tick, strobe_on, accept, fault, smp, seq_busy;
  logic              req, cyc_rd, stat_idle, w16;
  logic              h_valid;
  logic [31:0]       h_data;
  logic [2:0]        h_left;

  logic [WENT_W-1:0] wf_dout;
  logic              wf_push, wf_pop, wf_empty, wf_full;
  logic [BUS_W-1:0]  rf_din, rf_dout;
  logic              rf_push, rf_pop, rf_empty, rf_full;

  assign w16       = (pick[4:0] == 5'd15);
  assign go        = mode_en && !mode_rst && !timing[30] && !mode_gate;
  assign start     = go && !go_q;
  assign eng_clr   = rst || mode_rst || fault;
  assign stat_idle = !seq_busy && wf_empty && !h_valid;

  assign req = go && !done && (mode_dir ? !rf_full : h_valid);

  // ---------------- register file ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      timing    <= TIMING_RST;
      mode_en   <= 1'b0;
      mode_rst  <= 1'b0;
      mode_dir  <= 1'b0;
      mode_gate <= 1'b1;
      pick      <= PICK_RST;
      divr      <= '0;
      id_idx    <= '0;
    end else begin
      if (fault) mode_en <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          ADR_ID:     id_idx <= '0;
          ADR_TIMING: timing <= reg_wdata;
          ADR_MODE: begin
            mode_en   <= reg_wdata[0];
            mode_rst  <= reg_wdata[1];
            mode_dir  <= reg_wdata[2];
            mode_gate <= reg_wdata[4];
          end
          ADR_PICK:   pick <= reg_wdata[PICK_W-1:0];
          ADR_DIV:    divr <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (reg_rd && reg_addr == ADR_ID && id_idx != 2'd3) id_idx <= id_idx + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_ID: begin
          case (id_idx)
            2'd0:    reg_rdata <= SYNC_A;
            2'd1:    reg_rdata <= SYNC_B;
            2'd2:    reg_rdata <= COMP_CODE;
            default: reg_rdata <= VERSION_ID;
          endcase
        end
        ADR_TIMING: reg_rdata <= timing;
        ADR_MODE:   reg_rdata <= {27'h0, mode_gate, stat_idle, mode_dir, mode_rst, mode_en};
        ADR_PICK:   reg_rdata <= {{(32-PICK_W){1'b0}}, pick};
        ADR_FIFO:   reg_rdata <= rf_empty ? 32'h0 : {{(32-BUS_W){1'b0}}, rf_dout};
        ADR_DIV:    reg_rdata <= {{(32-DIV_W){1'b0}}, divr};
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // ---------------- queues ----------------
  assign wf_push = reg_wr && (reg_addr == ADR_FIFO);
  assign wf_pop  = !h_valid && !wf_empty;

  pbus_fifo #(.W(WENT_W), .DEPTH(WFIFO_DEPTH)) u_wfifo (
    .clk(clk), .clr(eng_clr), .push(wf_push), .din({reg_wsize, reg_wdata}),
    .pop(wf_pop), .dout(wf_dout), .empty(wf_empty), .full(wf_full)
  );

  assign rf_din  = w16 ? pb_din : {8'h00, pb_din[7:0]};
  assign rf_push = smp && cyc_rd;
  assign rf_pop  = reg_rd && (reg_addr == ADR_FIFO);

  pbus_fifo #(.W(BUS_W), .DEPTH(RFIFO_DEPTH)) u_rfifo (
    .clk(clk), .clr(eng_clr), .push(rf_push), .din(rf_din),
    .pop(rf_pop), .dout(rf_dout), .empty(rf_empty), .full(rf_full)
  );

  // ---------------- tick and cycle sequencer ----------------
  pbus_tick_div #(.DW(DIV_W)) u_tick (
    .clk(clk), .clr(rst || mode_rst), .div_m1(divr), .tick(tick)
  );

  pbus_strobe_seq #(.T0W(TW0_W), .T1W(TW1_W)) u_seq (
    .clk(clk), .clr(eng_clr), .tick(tick), .req(req),
    .tw0_m1(timing[23:20]), .tw1_m1(timing[29:24]),
    .strobe_on(strobe_on), .accept(accept), .fault(fault),
    .sample(smp), .busy(seq_busy)
  );

  // ---------------- transfer length ----------------
  always_ff @(posedge clk) begin
    if (eng_clr) begin
      go_q <= 1'b0;
      done <= 1'b1;
      rem  <= '0;
    end else begin
      go_q <= go;
      if (start) begin
        rem  <= timing[CNT_W-1:0];
        done <= 1'b0;
      end else if (accept) begin
        if (rem == '0) done <= 1'b1;
        else           rem  <= rem - 1'b1;
      end
    end
  end

  // ---------------- slice picker ----------------
  always_ff @(posedge clk) begin
    if (eng_clr) begin
      h_valid <= 1'b0;
      h_data  <= '0;
      h_left  <= '0;
    end else if (wf_pop) begin
      h_valid <= 1'b1;
      h_data  <= size_mask(wf_dout[33:32], wf_dout[31:0]);
      h_left  <= slice_count(wf_dout[33:32], w16, pick[9:5]);
    end else if (accept && !mode_dir) begin
      h_data  <= w16 ? {16'h0, h_data[31:16]} : {8'h0, h_data[31:8]};
      h_left  <= h_left - 3'd1;
      if (h_left == 3'd1) h_valid <= 1'b0;
    end
  end

  // ---------------- bus outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pb_dout <= '0;
      pb_csn  <= 1'b1;
      pb_cd   <= 1'b0;
      pb_doe  <= 1'b0;
    end else begin
      pb_csn <= timing[30];
      pb_cd  <= timing[18];
      pb_doe <= go && !mode_dir;
      if (accept && !mode_dir) pb_dout <= w16 ? h_data[15:0] : {8'h00, h_data[7:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (eng_clr)     cyc_rd <= 1'b0;
    else if (accept) cyc_rd <= mode_dir;
  end

  assign pb_wen = ~(strobe_on & ~cyc_rd);
  assign pb_ren = ~(strobe_on & cyc_rd);
endmodule

// File: rtl/pbus_xfer_checker.sv
module pbus_xfer_checker (
  input logic        clk,
  input logic        rst,
  input logic        pb_csn,
  input logic        pb_wen,
  input logic        pb_ren,
  input logic        pb_cd,
  input logic [15:0] pb_dout,
  input logic        hold_rst,
  input logic        eng_idle
);
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(!pb_wen && !pb_ren));

  assert_cs_low_on_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!pb_wen || !pb_ren) |-> !pb_csn);

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!pb_wen && $past(!pb_wen)) |-> $stable(pb_dout));

  assert_cd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!pb_wen && $past(!pb_wen)) |-> $stable(pb_cd));

  assert_not_drained_R9: assert property (@(posedge clk) disable iff (rst)
    (!pb_wen || !pb_ren) |-> !eng_idle);

  assert_quiet_in_hold_R12: assert property (@(posedge clk) disable iff (rst)
    hold_rst |=> (pb_wen && pb_ren));
endmodule

bind pbus_xfer_engine pbus_xfer_checker u_chk (
  .clk(clk), .rst(rst), .pb_csn(pb_csn), .pb_wen(pb_wen), .pb_ren(pb_ren),
  .pb_cd(pb_cd), .pb_dout(pb_dout), .hold_rst(mode_rst), .eng_idle(stat_idle)
);

// File: tb/tb_pbus_xfer_engine.sv
`timescale 1ns/1ps
module tb_pbus_xfer_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_wsize = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pb_din = '0;
  logic [15:0] pb_dout;
  logic        pb_doe, pb_csn, pb_wen, pb_ren, pb_cd;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pbus_xfer_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wsize(reg_wsize), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pb_din(pb_din), .pb_dout(pb_dout), .pb_doe(pb_doe), .pb_csn(pb_csn),
    .pb_wen(pb_wen), .pb_ren(pb_ren), .pb_cd(pb_cd)
  );

  // ---------------- bus monitor ----------------
  localparam int MAXR = 1024;
  int          nfall = 0, nrfall = 0, cyc = 0, lowcnt = 0;
  int          falltime [MAXR];
  int          lowlen   [MAXR];
  logic [15:0] capd     [MAXR];
  logic        capcd    [MAXR];
  logic        pw_q = 1'b1, pr_q = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!pb_wen && pw_q) begin
      if (nfall < MAXR) begin
        capd[nfall] = pb_dout;
        capcd[nfall] = pb_cd;
        falltime[nfall] = cyc;
      end
      nfall++;
      lowcnt = 1;
    end else if (!pb_wen) begin
      lowcnt++;
    end
    if (pb_wen && !pw_q && nfall > 0 && nfall <= MAXR) lowlen[nfall-1] = lowcnt;
    pw_q = pb_wen;
    if (!pb_ren && pr_q) begin
      pb_din = 16'hC300 + 16'(nrfall & 8'hFF);
      nrfall++;
    end
    pr_q = pb_ren;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wsize = sz;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_t(int n_m1, bit cd, int tw0f, int tw1f, bit csn);
    return {1'b0, csn, 6'(tw1f), 4'(tw0f), 1'b0, cd, 18'(n_m1)};
  endfunction

  function automatic logic [31:0] mk_m(bit en, bit hr, bit dir, bit gate);
    return {27'h0, gate, 1'b0, dir, hr, en};
  endfunction

  function automatic logic [31:0] mk_p(bit w16);
    return w16 ? {22'h0, 5'd1, 5'd15} : {22'h0, 5'd3, 5'd7};
  endfunction

  logic [31:0] ent_d [8];
  logic [1:0]  ent_s [8];
  logic [15:0] ex    [64];
  int          nx;

  // Expected slices per R7/R8
  function automatic void build_exp(int ne, bit w16);
    nx = 0;
    for (int e = 0; e < ne; e++) begin
      int ns;
      logic [31:0] v;
      v = (ent_s[e] == 2'd0) ? {24'h0, ent_d[e][7:0]} :
          (ent_s[e] == 2'd1) ? {16'h0, ent_d[e][15:0]} : ent_d[e];
      ns = (ent_s[e] == 2'd0) ? 1 : (ent_s[e] == 2'd1) ? (w16 ? 1 : 2) : (w16 ? 2 : 4);
      for (int k = 0; k < ns; k++) begin
        ex[nx] = w16 ? 16'(v >> (16*k)) : {8'h00, 8'(v >> (8*k))};
        nx++;
      end
    end
  endfunction

  task automatic write_xfer(input int tw0, input int tw1, input int dv, input bit w16,
                            input bit cd, input int ne);
    int base;
    logic [31:0] r;
    build_exp(ne, w16);
    wr(3'd1, mk_t(nx-1, cd, tw0-1, tw1-1, 1'b1));
    wr(3'd3, mk_p(w16));
    wr(3'd5, 32'(dv-1));
    for (int e = 0; e < ne; e++) wr(3'd4, ent_d[e], ent_s[e]);
    base = nfall;
    wr(3'd1, mk_t(nx-1, cd, tw0-1, tw1-1, 1'b0));
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b0));
    repeat (nx*(tw0+tw1)*dv + 30) @(negedge clk);
    chk(nfall - base == nx, "R4 strobe count", 32'(nfall-base), 32'(nx));
    for (int i = 0; i < nx; i++) begin
      if (base + i < MAXR) begin
        chk(capd[base+i] == ex[i], "R7/R8 slice data", {16'h0, capd[base+i]}, {16'h0, ex[i]});
        chk(capcd[base+i] == cd, "R5 cd line", 32'(capcd[base+i]), 32'(cd));
        chk(lowlen[base+i] == tw0*dv, "R3 active length", 32'(lowlen[base+i]), 32'(tw0*dv));
        if (i > 0)
          chk(falltime[base+i] - falltime[base+i-1] == (tw0+tw1)*dv, "R3 cycle period",
              32'(falltime[base+i] - falltime[base+i-1]), 32'((tw0+tw1)*dv));
      end
    end
    rd(3'd2, r);
    chk(r[3] == 1'b1, "R9 drained after transfer", r, 32'h8);
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b1));
    wr(3'd1, mk_t(0, 1'b0, tw0-1, tw1-1, 1'b1));
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r;
    int b, rb;
    void'($urandom(32'h1A2B3C));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(pb_csn && pb_wen && pb_ren, "R1 bus idle", {29'h0, pb_csn, pb_wen, pb_ren}, 32'h7);
    rd(3'd2, r); chk(r == 32'h18, "R1 mode reset", r, 32'h18);
    rd(3'd1, r); chk(r == 32'h4200_0000, "R1 timing reset", r, 32'h4200_0000);

    // R2 identification sequence
    wr(3'd0, 32'h0);
    rd(3'd0, r); chk(r == 32'h5555_5555, "R2 sync A", r, 32'h5555_5555);
    rd(3'd0, r); chk(r == 32'hAAAA_AAAA, "R2 sync B", r, 32'hAAAA_AAAA);
    rd(3'd0, r); chk(r == 32'h0000_D15B, "R2 component", r, 32'h0000_D15B);
    rd(3'd0, r); chk(r == 32'h0002_0001, "R2 version", r, 32'h0002_0001);
    rd(3'd0, r); chk(r == 32'h0002_0001, "R2 version holds", r, 32'h0002_0001);

    // R7 directed: word at width 8 then width 16, command cycles
    ent_d[0] = 32'h4433_2211; ent_s[0] = 2'd2;
    write_xfer(1, 3, 1, 1'b0, 1'b0, 1);
    ent_d[0] = 32'h4433_2211; ent_s[0] = 2'd2;
    write_xfer(2, 3, 2, 1'b1, 1'b1, 1);

    // R8 directed: byte and half at both widths
    ent_d[0] = 32'hFFFF_FF5A; ent_s[0] = 2'd0;
    ent_d[1] = 32'hFFFF_BEEF; ent_s[1] = 2'd1;
    write_xfer(1, 4, 1, 1'b0, 1'b1, 2);
    ent_d[0] = 32'hFFFF_FF5A; ent_s[0] = 2'd0;
    ent_d[1] = 32'hFFFF_BEEF; ent_s[1] = 2'd1;
    write_xfer(1, 4, 3, 1'b1, 1'b1, 2);

    // Random transfers (R3, R5, R7, R8)
    for (int it = 0; it < 6; it++) begin
      int ne;
      ne = 1 + int'($urandom_range(0, 3));
      for (int e = 0; e < ne; e++) begin
        ent_d[e] = $urandom;
        ent_s[e] = 2'($urandom_range(0, 2));
      end
      write_xfer(1 + int'($urandom_range(0, 3)), 3 + int'($urandom_range(0, 3)),
                 1 + int'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ne);
    end

    // R4: count shorter than queued data; R9 pending; R12 hold flushes
    wr(3'd3, mk_p(1'b0)); wr(3'd5, 32'h0);
    wr(3'd1, mk_t(4, 1'b1, 0, 2, 1'b1));
    wr(3'd4, 32'h0403_0201); wr(3'd4, 32'h0807_0605);
    b = nfall;
    wr(3'd1, mk_t(4, 1'b1, 0, 2, 1'b0));
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b0));
    repeat (80) @(negedge clk);
    chk(nfall - b == 5, "R4 count limits cycles", 32'(nfall-b), 32'd5);
    rd(3'd2, r); chk(r[3] == 1'b0, "R9 queued data pending", r, 32'h0);
    wr(3'd2, mk_m(1'b1, 1'b1, 1'b0, 1'b0));
    wr(3'd4, 32'h1111_1111);
    repeat (20) @(negedge clk);
    chk(nfall - b == 5, "R12 no strobe in hold", 32'(nfall-b), 32'd5);
    rd(3'd2, r); chk(r[3] == 1'b1, "R12 hold empties queue", r, 32'h8);
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b0));
    repeat (60) @(negedge clk);
    chk(nfall - b == 5, "R12 dropped write emits nothing", 32'(nfall-b), 32'd5);
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b1));
    wr(3'd1, mk_t(0, 1'b0, 0, 2, 1'b1));

    // R6: chip select high blocks cycles, then lowering it runs them
    wr(3'd3, mk_p(1'b1));
    wr(3'd1, mk_t(1, 1'b1, 0, 2, 1'b1));
    wr(3'd4, 32'hCAFE_F00D);
    b = nfall;
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b0));
    repeat (60) @(negedge clk);
    chk(nfall == b, "R6 no cycles with cs high", 32'(nfall-b), 32'd0);
    chk(pb_csn == 1'b1, "R6 csn follows bit", 32'(pb_csn), 32'd1);
    wr(3'd1, mk_t(1, 1'b1, 0, 2, 1'b0));
    repeat (4) @(negedge clk);
    rd(3'd2, r); chk(r[3] == 1'b0, "R9 busy mid transfer", r, 32'h0);
    repeat (40) @(negedge clk);
    chk(nfall - b == 2, "R6 cycles after cs low", 32'(nfall-b), 32'd2);
    if (b + 1 < MAXR)
      chk(capd[b] == 16'hF00D && capd[b+1] == 16'hCAFE, "R7 halfword order",
          {capd[b+1], capd[b]}, 32'hCAFE_F00D);
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b1));
    wr(3'd1, mk_t(0, 1'b0, 0, 2, 1'b1));

    // R10: recovery field 1 triggers self-reset
    wr(3'd1, mk_t(1, 1'b1, 0, 1, 1'b1));
    wr(3'd4, 32'h1234_5678);
    b = nfall;
    wr(3'd1, mk_t(1, 1'b1, 0, 1, 1'b0));
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    chk(nfall == b, "R10 no strobe on short recovery", 32'(nfall-b), 32'd0);
    rd(3'd2, r);
    chk(r[0] == 1'b0 && r[3] == 1'b1, "R10 enable cleared and flushed", r, 32'h8);
    wr(3'd2, mk_m(1'b0, 1'b0, 1'b0, 1'b1));
    wr(3'd1, mk_t(0, 1'b0, 0, 2, 1'b1));

    // R11: read transfer, 16-bit, three cycles
    wr(3'd3, mk_p(1'b1)); wr(3'd5, 32'h1);
    wr(3'd1, mk_t(2, 1'b1, 1, 2, 1'b1));
    b = nfall; rb = nrfall;
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b1, 1'b1));
    wr(3'd1, mk_t(2, 1'b1, 1, 2, 1'b0));
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b1, 1'b0));
    repeat (60) @(negedge clk);
    chk(nrfall - rb == 3, "R11 read strobes", 32'(nrfall-rb), 32'd3);
    chk(nfall == b, "R11 no write strobe", 32'(nfall-b), 32'd0);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] e;
      e = {16'h0, 16'hC300 + 16'((rb + k) & 8'hFF)};
      rd(3'd4, r);
      chk(r == e, "R11 captured read data", r, e);
    end
    rd(3'd4, r); chk(r == 32'h0, "R11 empty capture reads zero", r, 32'h0);
    wr(3'd2, mk_m(1'b1, 1'b0, 1'b0, 1'b1));
    wr(3'd1, mk_t(0, 1'b0, 0, 2, 1'b1));

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule